// File: doc/BRIEF.md
# Overcurrent and Thermal Hiccup Supervisor

This block decides, cycle by cycle, whether one converter channel may switch. It watches an overload flag, an over-temperature trip flag, a temperature recovery flag, the channel enable and an input undervoltage flag. All of its timing is counted in switching cycles, using a free-running cycle strobe that keeps ticking while the power stage is stopped.

A sustained overload, or an over-temperature trip, stops the channel for a hiccup interval. When that interval ends, the channel restarts. Every start raises a one-cycle request that restarts the soft-start ramp.

Each channel has its own instance, and instances share no state. A fault on one channel therefore never disturbs another. The persistence window (`PERSIST_CYC`, default 512) and the hiccup length (`HICCUP_CYC`, default 16384) are parameters.

Top module: `hiccup_supervisor`

## Requirements
- R1: While reset is asserted, `run` and `ss_restart` are 0. The block leaves reset in the stopped state.
- R2: At the first clock edge where `en` is 0 or `uv` is 1, `run` falls. Any hiccup or persistence count in progress is abandoned. When `en` is 1 and `uv` is 0 again, the channel starts at the next edge.
- R3: While running, a strobe cycle with `ovld` clear resets the overload persistence count to zero. The channel keeps running as long as no more than `PERSIST_CYC` consecutive strobe cycles carry `ovld`. Clock edges without `cyc_stb` leave the count unchanged.
- R4: The strobe edge that sees `ovld` for the (`PERSIST_CYC`+1)-th consecutive strobe stops the channel. `run` is 0 from the following cycle.
- R5: After an overload shutdown, the channel restarts at the strobe edge that completes `HICCUP_CYC` strobes spent waiting. During the wait, `ovld` has no effect.
- R6: `th_trip` at 1 stops the channel at the next clock edge from any enabled state, whether running or waiting. It takes precedence over every overload condition.
- R7: After a thermal trip, no hiccup strobes are counted until an edge where `th_ok` is 1 and `th_trip` is 0. From the next cycle on, the block counts `HICCUP_CYC` strobes and then restarts.
- R8: A `th_trip` during any hiccup wait discards the count. The thermal sequence then starts again by waiting for `th_ok`.
- R9: `ss_restart` is 1 for exactly the first cycle in which `run` is 1 after being 0. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One-clock strobe per switching cycle, free running |
| ovld | input | 1 | Overload seen in the current switching cycle |
| th_trip | input | 1 | Junction temperature above trip point |
| th_ok | input | 1 | Junction temperature below recovery point |
| en | input | 1 | Channel enable |
| uv | input | 1 | Input supply undervoltage |
| run | output | 1 | Switching allowed for the gate sequencer |
| ss_restart | output | 1 | One-cycle soft-start restart request |

## Verification
The assertions assume that the fault flags and `cyc_stb` are synchronous to `clk` and hold their value for a whole clock period. They also assume `cyc_stb` is a single-cycle pulse. The stimulus drives every input on the falling edge only. It varies the strobe spacing at random and mixes regimes of heavy overload, rare thermal trips with late recovery, and occasional disable or undervoltage. The bench runs with a short persistence window and a short hiccup length so that many complete shutdown and restart sequences fit in the run.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [2:0] {
    SUP_OFF  = 3'd0,
    SUP_RUN  = 3'd1,
    SUP_OCW  = 3'd2,
    SUP_HOT  = 3'd3,
    SUP_THW  = 3'd4
  } sup_state_t;
endpackage

// File: rtl/hic_persist.sv
module hic_persist #(
  parameter int PERSIST_CYC = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic stb,
  input  logic ovld,
  output logic trip
);
  localparam int CW = $clog2(PERSIST_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PERSIST_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!act) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (stb) begin
      cnt_en = 1'b1;
      cnt_d  = ovld ? ((cnt_q == LIMIT) ? '0 : cnt_q + 1'b1) : '0;
    end
  end

  assign trip = act && stb && ovld && (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r3_clear_on_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act && stb && !ovld) |=> (cnt_q == '0));
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !stb) |=> $stable(cnt_q));
  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/hic_wait_timer.sv
module hic_wait_timer #(
  parameter int HICCUP_CYC = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic stb,
  output logic done
);
  localparam int CW = (HICCUP_CYC > 1) ? $clog2(HICCUP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HICCUP_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!act) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (stb) begin
      cnt_en = 1'b1;
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign done = act && stb && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (cnt_q == '0));
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor
  import hiccup_pkg::*;
#(
  parameter int PERSIST_CYC = 512,
  parameter int HICCUP_CYC  = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_stb,
  input  logic ovld,
  input  logic th_trip,
  input  logic th_ok,
  input  logic en,
  input  logic uv,
  output logic run,
  output logic ss_restart
);
  sup_state_t state_q, state_d;
  logic       rst_req_q, rst_req_d;
  logic       oc_trip, wait_done, in_wait;

  assign in_wait = (state_q == SUP_OCW) || (state_q == SUP_THW);

  hic_persist #(.PERSIST_CYC(PERSIST_CYC)) u_persist (
    .clk  (clk),
    .rst_n(rst_n),
    .act  (state_q == SUP_RUN),
    .stb  (cyc_stb),
    .ovld (ovld),
    .trip (oc_trip)
  );

  hic_wait_timer #(.HICCUP_CYC(HICCUP_CYC)) u_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .act  (in_wait),
    .stb  (cyc_stb),
    .done (wait_done)
  );

  always_comb begin
    state_d = state_q;
    if (!en || uv) begin
      state_d = SUP_OFF;
    end else if (th_trip) begin
      state_d = SUP_HOT;
    end else begin
      unique case (state_q)
        SUP_OFF: state_d = SUP_RUN;
        SUP_RUN: if (oc_trip)   state_d = SUP_OCW;
        SUP_OCW: if (wait_done) state_d = SUP_RUN;
        SUP_HOT: if (th_ok)     state_d = SUP_THW;
        SUP_THW: if (wait_done) state_d = SUP_RUN;
        default: state_d = SUP_OFF;
      endcase
    end
    rst_req_d = (state_d == SUP_RUN) && (state_q != SUP_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SUP_OFF;
      rst_req_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rst_req_q <= rst_req_d;
    end
  end

  assign run        = (state_q == SUP_RUN);
  assign ss_restart = rst_req_q;

  a_r2_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || uv) |=> !run);
  a_r6_trip_stops: assert property (@(posedge clk) disable iff (!rst_n)
    th_trip |=> !run);
  a_r7_hot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SUP_HOT && !th_ok && en && !uv) |=> !run);
  a_r9_rise_requests: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ss_restart);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);
  a_r9_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> run);
endmodule

// File: tb/sim_hiccup_supervisor.sv
module sim_hiccup_supervisor;
  localparam int PC = 12;
  localparam int HC = 40;

  logic clk = 1'b0;
  logic rst_n, cyc_stb, ovld, th_trip, th_ok, en, uv;
  logic run, ss_restart;
  int   n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  hiccup_supervisor #(.PERSIST_CYC(PC), .HICCUP_CYC(HC)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ovld(ovld),
    .th_trip(th_trip), .th_ok(th_ok), .en(en), .uv(uv),
    .run(run), .ss_restart(ss_restart));

  // reference model: 0 off, 1 run, 2 overload wait, 3 hot, 4 thermal wait
  int    ms, mp, mw;
  logic  mrs;
  string mtag;

  always @(posedge clk or negedge rst_n) begin
    int ns, np, nw;
    if (!rst_n) begin
      ms <= 0; mp <= 0; mw <= 0; mrs <= 1'b0; mtag <= "R1";
    end else begin
      ns = ms; np = mp; nw = mw;
      if (!en || uv) begin
        ns = 0; mtag <= "R2";
      end else if (th_trip) begin
        ns = 3; mtag <= (ms == 4) ? "R8" : "R6";
      end else begin
        case (ms)
          0: begin ns = 1; mtag <= "R2"; end
          1: if (cyc_stb) begin
               if (!ovld) np = 0;
               else if (mp == PC) begin ns = 2; mtag <= "R4"; end
               else begin np = mp + 1; mtag <= "R3"; end
             end
          2: if (cyc_stb) begin
               if (mw == HC - 1) ns = 1; else nw = mw + 1;
               mtag <= "R5";
             end
          3: if (th_ok) begin ns = 4; mtag <= "R7"; end
          4: if (cyc_stb) begin
               if (mw == HC - 1) ns = 1; else nw = mw + 1;
               mtag <= "R7";
             end
          default: ns = 0;
        endcase
      end
      if (ns != 1) np = 0;
      if (ns != 2 && ns != 4) nw = 0;
      if (ns == 3 && ms != 3) nw = 0;
      mrs <= (ns == 1) && (ms != 1);
      ms <= ns; mp <= np; mw <= nw;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk(mtag, run, ms == 1, "run");
    chk(mrs ? "R9" : mtag, ss_restart, mrs, "ss_restart");
  endtask

  task automatic drive(input int p_stb, input int p_ov, input int p_trip,
                       input int p_ok, input int p_dis);
    cyc_stb = ($urandom % 100) < p_stb;
    ovld    = ($urandom % 100) < p_ov;
    th_trip = ($urandom % 1000) < p_trip;
    th_ok   = ($urandom % 100) < p_ok;
    en      = !(($urandom % 1000) < p_dis);
    uv      = ($urandom % 1000) < (p_dis / 2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cyc_stb = 0; ovld = 0; th_trip = 0; th_ok = 0; en = 1; uv = 0;
    repeat (3) @(negedge clk);
    chk("R1", run, 1'b0, "run in reset");
    chk("R1", ss_restart, 1'b0, "ss_restart in reset");
    rst_n = 1'b1;
    tick();
    chk("R9", ss_restart, 1'b1, "first start request");
    // directed: overload on every strobe, strobe every cycle
    cyc_stb = 1; ovld = 1;
    for (int i = 0; i < PC; i++) tick();
    chk("R3", run, 1'b1, "still running at window edge");
    tick();
    chk("R4", run, 1'b0, "stopped past window");
    for (int i = 0; i < HC - 1; i++) tick();
    chk("R5", run, 1'b0, "one strobe short of restart");
    tick();
    chk("R5", run, 1'b1, "restart after hiccup");
    // directed: thermal trip, late recovery
    ovld = 0; th_trip = 1; tick(); th_trip = 0;
    chk("R6", run, 1'b0, "trip stops");
    for (int i = 0; i < 2 * HC; i++) tick();
    chk("R7", run, 1'b0, "no count before recovery");
    th_ok = 1; tick(); th_ok = 0;
    for (int i = 0; i < HC / 2; i++) tick();
    th_trip = 1; tick(); th_trip = 0;
    th_ok = 1;
    for (int i = 0; i < HC; i++) tick();
    chk("R8", run, 1'b0, "retrip restarted sequence");
    tick();
    chk("R7", run, 1'b1, "thermal restart");
    th_ok = 0;
    en = 0; tick(); en = 1;
    chk("R2", run, 1'b0, "disable stops");
    // random regimes
    for (int i = 0; i < 3000; i++) begin drive(70, 95, 0, 10, 0); tick(); end
    for (int i = 0; i < 3000; i++) begin drive(30, 80, 3, 5, 2); tick(); end
    for (int i = 0; i < 3000; i++) begin drive(50, 50, 5, 30, 5); tick(); end
    for (int i = 0; i < 2000; i++) begin drive(100, 97, 2, 50, 1); tick(); end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule